// File: doc/BRIEF.md
# Relative Branch Timing Unit

This block carries out the control sequencing and program-counter update for a conditional relative branch in an 8-bit processor core with a 16-bit program counter. The core supplies three values:

- the program counter, which already points past the branch instruction;
- the fetched signed 8-bit displacement;
- a flag saying whether the branch condition holds.

The block then takes two, three or four cycles to produce the next program counter, depending on the branch outcome.

A branch that is not taken ends immediately. A taken branch spends one extra cycle adding the displacement to the low byte of the counter. When that addition leaves the 256-byte page, one further cycle moves the high byte up or down by one. While a branch is in flight the block reports busy and a cycle number. It raises a one-cycle done pulse in the last cycle, and the new program counter is valid in that cycle.

Cycle 1 of a branch is the cycle in which the core presents the request. The block numbers the cycles that follow as 2, 3 and 4.

Top module: `relative_branch_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0, `cycle_cnt` is 0 and `new_pc` is 0x0000.
- R2: A request with `req_taken` = 0 raises `done` in the first cycle after the accepting clock edge, with `cycle_cnt` = 2 and `new_pc` equal to `req_pc`. This holds even when the displacement would have crossed a page.
- R3: A taken request whose target stays in the base page raises `done` in the second cycle after acceptance, with `cycle_cnt` = 3. In that case `new_pc` = `req_pc` + sign-extended `req_disp`, with the high byte unchanged. The displacement covers the full range -128 (0x80) to +127 (0x7F).
- R4: A taken request whose target lies in another page raises `done` in the third cycle after acceptance, with `cycle_cnt` = 4. `cycle_cnt` never exceeds 4.
- R5: On a page cross the high byte is incremented when a positive displacement carries out of the low byte. It is decremented when a negative displacement borrows. It wraps modulo 256, so 0xFFF0+0x20 gives 0x0010 and 0x0005-0x10 gives 0xFFF5.
- R6: `done` lasts exactly one cycle. `busy` is 1 from the cycle after acceptance through the `done` cycle, and is 0 in the cycle after `done`.
- R7: While idle `cycle_cnt` is 0. In the first busy cycle it is 2, and it rises by one in each later busy cycle.
- R8: `req_valid` is ignored while `busy` is 1, including in the `done` cycle. Such a request starts no branch and does not change the result of the branch in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Branch request; accepted at an edge where `busy` is 0 |
| req_pc | input | 16 | Program counter pointing past the branch |
| req_disp | input | 8 | Signed displacement, two's complement |
| req_taken | input | 1 | Branch condition holds |
| busy | output | 1 | A branch is in flight |
| done | output | 1 | One-cycle pulse in the final cycle |
| new_pc | output | 16 | Next program counter, valid while `done` is 1 |
| cycle_cnt | output | 3 | Number of the current branch cycle (2 to 4), 0 when idle |

## Verification
A request is accepted at a rising edge. From that edge, `done` is due one, two or three cycles later for the not-taken, same-page and page-crossing cases. `new_pc` and a `cycle_cnt` of 2, 3 or 4 are due in the same cycle.

The driver pushes the expected counter and cycle number into a queue when it presents each request. The monitor samples on falling edges and counts busy cycles since acceptance. On each `done` it checks that count against the expected latency as well as the outputs. One falling edge after each `done` it also checks that `busy` and `done` have dropped.

// File: rtl/brt_pkg.sv
// Package: shared types for the relative branch timing unit.
// Assumes: one branch in flight at a time; cycle 1 is the request cycle.
package brt_pkg;

    // Sequencer states; EVAL, LOW and HIGH correspond to branch cycles 2, 3 and 4.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } brt_state_e;

    // High-byte adjustment demanded by the low-byte addition.
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_INC  = 2'd1,
        ADJ_DEC  = 2'd2
    } brt_adj_e;

    // Cycle numbers of the final cycle of each branch outcome.
    localparam int CYC_FIRST  = 2;
    localparam int CYC_SAME   = 3;
    localparam int CYC_CROSS  = 4;

endpackage

// File: rtl/brt_low_adder.sv
// Module: brt_low_adder
// Adds a signed displacement to the low byte of the program counter and
// classifies the result as a carry into the next page, a borrow into the
// previous page, or no page change.
// Assumes: displacement width equals the low-part width (two's complement).
module brt_low_adder
    import brt_pkg::*;
#(
    parameter int LO_W = 8
) (
    input  logic [LO_W-1:0] lo_in,
    input  logic [LO_W-1:0] disp_in,
    output logic [LO_W-1:0] lo_sum,
    output brt_adj_e        adj_out
);

    logic [LO_W:0] wide_sum;
    logic          carry_out;
    logic          disp_neg;

    // Unsigned add with one extra bit to catch the carry.
    always_comb begin
        wide_sum  = {1'b0, lo_in} + {1'b0, disp_in};
        lo_sum    = wide_sum[LO_W-1:0];
        carry_out = wide_sum[LO_W];
        disp_neg  = disp_in[LO_W-1];
    end

    // Positive displacement with carry: next page; negative without carry: previous page.
    always_comb begin
        if (!disp_neg && carry_out) begin
            adj_out = ADJ_INC;
        end else if (disp_neg && !carry_out) begin
            adj_out = ADJ_DEC;
        end else begin
            adj_out = ADJ_NONE;
        end
    end

endmodule

// File: rtl/brt_high_fix.sv
// Module: brt_high_fix
// Applies the page adjustment to the high part of the program counter:
// plus one, minus one or unchanged, wrapping at the width of the part.
// Assumes: adj_in is ADJ_NONE whenever no page is crossed.
module brt_high_fix
    import brt_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] hi_in,
    input  brt_adj_e        adj_in,
    output logic [HI_W-1:0] hi_out
);

    localparam logic [HI_W-1:0] ONE = HI_W'(1);

    // Select increment, decrement or pass-through.
    always_comb begin
        unique case (adj_in)
            ADJ_INC: hi_out = hi_in + ONE;
            ADJ_DEC: hi_out = hi_in - ONE;
            default: hi_out = hi_in;
        endcase
    end

endmodule

// File: rtl/brt_sequencer.sv
// Module: brt_sequencer
// Control state machine for one relative branch. Accepts a request only while
// idle, then steps EVAL -> LOW -> HIGH as the outcome requires. It produces
// load strobes for the datapath, busy, the final-cycle done and the cycle number.
// Assumes: taken_q and adj_q are registered by the datapath in step with the
// strobes issued here.
module brt_sequencer
    import brt_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             taken_q,
    input  brt_adj_e         adj_q,
    output logic             accept,
    output logic             lo_load,
    output logic             hi_load,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cycle_cnt
);

    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(CYC_FIRST);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    brt_state_e state_q;
    brt_state_e state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state selection from the stored outcome of the branch.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = taken_q ? ST_LOW : ST_IDLE;
            ST_LOW:  state_d = (adj_q != ADJ_NONE) ? ST_HIGH : ST_IDLE;
            ST_HIGH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobes and status derived from the current state.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        accept  = (state_q == ST_IDLE) && req_valid;
        lo_load = (state_q == ST_EVAL) && taken_q;
        hi_load = (state_q == ST_LOW) && (adj_q != ADJ_NONE);
        done    = ((state_q == ST_EVAL) && !taken_q)
               || ((state_q == ST_LOW) && (adj_q == ADJ_NONE))
               || (state_q == ST_HIGH);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Cycle counter: starts at 2 on acceptance, steps while busy, clears after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= CNT_START;
        end else if (done) begin
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cycle_cnt = cnt_q;

endmodule

// File: rtl/relative_branch_unit.sv
// Module: relative_branch_unit (top)
// Sequences a conditional relative branch and delivers the next program counter.
// The datapath holds the counter split into a low part (the width of the
// displacement) and a high part. The low part is updated in the first extra
// cycle and the high part in the page fix-up cycle.
// Assumes: req_pc already points past the branch; req_disp is two's complement.
module relative_branch_unit
    import brt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_taken,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   new_pc,
    output logic [CNT_W-1:0]  cycle_cnt
);

    localparam int LO_W = DISP_W;
    localparam int HI_W = PC_W - DISP_W;

    logic [HI_W-1:0]   hi_q;
    logic [LO_W-1:0]   lo_q;
    logic [DISP_W-1:0] disp_q;
    logic              taken_q;
    brt_adj_e          adj_q;

    logic              accept;
    logic              lo_load;
    logic              hi_load;
    logic [LO_W-1:0]   lo_sum;
    brt_adj_e          adj_calc;
    logic [HI_W-1:0]   hi_next;

    brt_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .taken_q   (taken_q),
        .adj_q     (adj_q),
        .accept    (accept),
        .lo_load   (lo_load),
        .hi_load   (hi_load),
        .busy      (busy),
        .done      (done),
        .cycle_cnt (cycle_cnt)
    );

    brt_low_adder #(.LO_W(LO_W)) u_lo (
        .lo_in   (lo_q),
        .disp_in (disp_q),
        .lo_sum  (lo_sum),
        .adj_out (adj_calc)
    );

    brt_high_fix #(.HI_W(HI_W)) u_hi (
        .hi_in  (hi_q),
        .adj_in (adj_q),
        .hi_out (hi_next)
    );

    // Capture the request, then apply the low-part and high-part updates in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            disp_q  <= '0;
            taken_q <= 1'b0;
            adj_q   <= ADJ_NONE;
        end else if (accept) begin
            hi_q    <= req_pc[PC_W-1:LO_W];
            lo_q    <= req_pc[LO_W-1:0];
            disp_q  <= req_disp;
            taken_q <= req_taken;
            adj_q   <= ADJ_NONE;
        end else if (lo_load) begin
            lo_q    <= lo_sum;
            adj_q   <= adj_calc;
        end else if (hi_load) begin
            hi_q    <= hi_next;
        end
    end

    assign new_pc = {hi_q, lo_q};

endmodule

// File: rtl/brt_checker.sv
// Module: brt_checker
// Temporal checks on the ports of relative_branch_unit, attached by bind.
// Keeps its own copy of the accepted base counter to judge page changes.
module brt_checker #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PC_W-1:0]   req_pc,
    input logic              busy,
    input logic              done,
    input logic [PC_W-1:0]   new_pc,
    input logic [CNT_W-1:0]  cycle_cnt
);

    localparam int HI_LSB = DISP_W;

    logic [PC_W-1:0] base_q;

    // Record the base counter of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (req_valid && !busy) begin
            base_q <= req_pc;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_MID_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && cycle_cnt == '0)); // R7
    AST_START_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && cycle_cnt == CNT_W'(2))); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1))); // R7
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cycle_cnt <= CNT_W'(4))); // R4
    AST_NOT_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycle_cnt == CNT_W'(2)) |-> (new_pc == base_q)); // R2
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycle_cnt == CNT_W'(3)) |-> (new_pc[PC_W-1:HI_LSB] == base_q[PC_W-1:HI_LSB])); // R3
    AST_PAGE_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycle_cnt == CNT_W'(4)) |-> (new_pc[PC_W-1:HI_LSB] != base_q[PC_W-1:HI_LSB])); // R5

endmodule

bind relative_branch_unit brt_checker #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pc    (req_pc),
    .busy      (busy),
    .done      (done),
    .new_pc    (new_pc),
    .cycle_cnt (cycle_cnt)
);

// File: tb/relative_branch_unit_tb.sv
`timescale 1ns/1ps
module relative_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_pc = '0;
    logic [7:0]  req_disp = '0;
    logic        req_taken = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] new_pc;
    logic [2:0]  cycle_cnt;

    int checks = 0;
    int failures = 0;
    int sent = 0;
    int completed = 0;
    bit finished = 0;

    logic [15:0] exp_pc_q[$];
    int          exp_cyc_q[$];

    always #2.5 clk = ~clk;

    relative_branch_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_pc    (req_pc),
        .req_disp  (req_disp),
        .req_taken (req_taken),
        .busy      (busy),
        .done      (done),
        .new_pc    (new_pc),
        .cycle_cnt (cycle_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: waits for idle, presents one request, pushes the expected result.
    task automatic send(input logic [15:0] pc, input logic [7:0] d, input logic tk);
        logic [15:0] tgt;
        int cyc;
        while (busy) @(negedge clk);
        tgt = pc + {{8{d[7]}}, d};
        if (!tk) cyc = 2;
        else if (tgt[15:8] != pc[15:8]) cyc = 4;
        else cyc = 3;
        exp_pc_q.push_back(tk ? tgt : pc);
        exp_cyc_q.push_back(cyc);
        sent++;
        req_pc = pc; req_disp = d; req_taken = tk; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: latency, cycle number, counter value and done/busy release.
    int  run_len = 0;
    bit  prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                check(!done && !busy, "R6 release after done", {done, busy}, 0);
            end
            if (busy) run_len++;
            if (done) begin
                if (exp_pc_q.size() == 0) begin
                    check(0, "R8 unexpected done", 1, 0);
                end else begin
                    automatic logic [15:0] epc = exp_pc_q.pop_front();
                    automatic int ecyc = exp_cyc_q.pop_front();
                    completed++;
                    check(int'(cycle_cnt) == ecyc, "R2/R3/R4 cycle_cnt", cycle_cnt, ecyc);
                    check(run_len == ecyc - 1, "R2/R3/R4 latency", run_len, ecyc - 1);
                    check(new_pc == epc, (ecyc == 4) ? "R5 new_pc" : "R2/R3 new_pc", new_pc, epc);
                end
            end
            if (!busy) run_len = 0;
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && cycle_cnt == 0 && new_pc == 0, "R1 reset state",
              {busy, done, cycle_cnt, new_pc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && cycle_cnt == 0, "R7 idle count", cycle_cnt, 0);

        send(16'h1234, 8'h10, 1'b0); // R2 not taken
        send(16'h12F0, 8'h20, 1'b0); // R2 not taken, disp would cross
        send(16'h1234, 8'h10, 1'b1); // R3 forward same page
        send(16'h1234, 8'hE0, 1'b1); // R3 backward same page
        send(16'h1000, 8'h7F, 1'b1); // R3 +127
        send(16'h1080, 8'h80, 1'b1); // R3 -128 same page
        send(16'h12F0, 8'h20, 1'b1); // R4/R5 forward cross
        send(16'h1205, 8'hF0, 1'b1); // R4/R5 backward cross
        send(16'h12FF, 8'h01, 1'b1); // R5 edge of page
        send(16'h1010, 8'h80, 1'b1); // R5 -128 cross
        send(16'hFFF0, 8'h20, 1'b1); // R5 wrap upward
        send(16'h0005, 8'hF0, 1'b1); // R5 wrap downward

        // R8: requests held high through a whole branch, including its done cycle.
        send(16'h40F8, 8'h10, 1'b1);
        req_pc = 16'h7777; req_disp = 8'h01; req_taken = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!busy && !done, "R8 ignored request started nothing", {busy, done}, 0);
        end

        send(16'h2000, 8'h05, 1'b1); // back to back after noise
        while (busy || exp_pc_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(completed == sent, "R2/R3/R4 all branches completed", completed, sent);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule